// File: doc/BRIEF.md
# Coded Two-Stage Stereo Volume and Balance Gain

This block scales a stream of signed stereo PCM samples by gains chosen with small register codes, as a TV or set-top audio path would. In the loudspeaker mode, a 6-bit coarse code sets the gain of both channels together. A 5-bit fine code for each channel then trims that channel on its own, which gives volume, balance and mute. The two stage gains add in decibels.

In the headphone mode, each channel takes a single 6-bit code with 2 dB steps. The loudspeaker codes then have no effect.

The codes are taken with each sample and turned into a decibel value. A decibel-indexed table gives the linear fixed-point coefficient for that value. The coefficient multiplies the sample, and the result is rounded and saturated. A mute code forces the channel output to exactly zero. The pipeline is two registers deep, and one strobe marks valid data at the input and at the output.

Top module: `stereo_gain_stage`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and both outputs are 0.
- R2: A sample taken with `in_valid` high appears at the outputs exactly two clock edges later, with `out_valid` high for that one cycle. `out_valid` is never high without such an input.
- R3: Coarse code 0x30 is 0 dB. Each step up adds 1 dB, up to +15 dB at 0x3F. Each step down removes 1 dB, down to -40 dB at 0x08. Coarse codes below 0x08 act as 0x08.
- R4: Fine code 0x1F is 0 dB. Each step down removes 1 dB, down to -23 dB at 0x08. Left and right fine codes act independently.
- R5: In the loudspeaker mode, a fine code of 0x07 or below mutes that channel, and its output is exactly 0.
- R6: In the loudspeaker mode, the gain of a channel in dB is the coarse gain plus that channel's fine gain.
- R7: With `hp_mode` = 1, code 0x3F is 0 dB and each step down removes 2 dB, down to -70 dB at 0x1C. Codes 0x1B and below give exactly 0. The loudspeaker codes are ignored in this mode.
- R8: For inputs with magnitude up to a quarter of full scale, each output is within 1 LSB of the input times 10^(dB/20), rounded to the nearest integer. A zero input gives a zero output.
- R9: Results beyond the output range saturate to the largest positive or most negative sample value.
- R10: While `out_valid` is 0, the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_mode | input | 1 | 1 selects the single-stage headphone codes |
| spk_common | input | 6 | Coarse loudspeaker code, shared by both channels |
| spk_fine_l | input | 5 | Fine loudspeaker code, left channel |
| spk_fine_r | input | 5 | Fine loudspeaker code, right channel |
| hp_code_l | input | 6 | Headphone code, left channel |
| hp_code_r | input | 6 | Headphone code, right channel |
| in_valid | input | 1 | Input sample strobe |
| in_l | input | SAMPLE_W | Left input sample, signed |
| in_r | input | SAMPLE_W | Right input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | SAMPLE_W | Left output sample, signed |
| out_r | output | SAMPLE_W | Right output sample, signed |

## Verification
Every pairing of the coarse code with the fine code is driven in the loudspeaker mode. The right fine code is scrambled against the left one, so a swapped or shared channel decode produces a mismatch. The input amplitude also changes with the codes, so a wrong table index cannot hide behind one value. Every headphone code is then driven while the loudspeaker codes hold mute values; any leak of the loudspeaker path zeroes the output or shifts its gain. Separate cases cover the exact 0 dB point, positive and negative saturation at +15 dB, the two-edge latency, and outputs holding while stale inputs change.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // code anchors (offset binary codes)
  localparam logic [5:0] SPK1_ZERO  = 6'h30;
  localparam logic [5:0] SPK1_TOP   = 6'h3F;
  localparam logic [5:0] SPK1_FLOOR = 6'h08;
  localparam logic [4:0] SPK2_ZERO  = 5'h1F;
  localparam logic [4:0] SPK2_FLOOR = 5'h08;
  localparam logic [5:0] HP_ZERO    = 6'h3F;
  localparam logic [5:0] HP_FLOOR   = 6'h1C;
  localparam int         HP_STEP_DB = 2;

  // span of the decibel table, derived from the anchors
  localparam int DB_MAX     = int'(SPK1_TOP) - int'(SPK1_ZERO);
  localparam int DB_SPK_MIN = (int'(SPK1_FLOOR) - int'(SPK1_ZERO))
                            + (int'(SPK2_FLOOR) - int'(SPK2_ZERO));
  localparam int DB_HP_MIN  = HP_STEP_DB * (int'(HP_FLOOR) - int'(HP_ZERO));
  localparam int DB_MIN     = (DB_SPK_MIN < DB_HP_MIN) ? DB_SPK_MIN : DB_HP_MIN;
  localparam int DB_SPAN    = DB_MAX - DB_MIN + 1;

  // linear gain for a whole-dB value as an unsigned fixed-point integer
  function automatic int db_to_fixed(input int db, input int frac);
    real lin;
    lin = 10.0 ** (real'(db) / 20.0);
    return $rtoi(lin * (2.0 ** frac) + 0.5);
  endfunction

endpackage

// File: rtl/gain_code_decode.sv
module gain_code_decode
  import sg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             hp_mode,
  input  logic [5:0]       coarse,
  input  logic [4:0]       fine,
  input  logic [5:0]       hp_code,
  output logic [IDX_W-1:0] rom_idx,
  output logic             mute
);

  logic [5:0] coarse_c;
  int         db_spk;
  int         db_hp;
  int         db_sel;

  always_comb begin
    coarse_c = (coarse < SPK1_FLOOR) ? SPK1_FLOOR : coarse;
    db_spk   = (int'(coarse_c) - int'(SPK1_ZERO)) + (int'(fine) - int'(SPK2_ZERO));
    db_hp    = HP_STEP_DB * (int'(hp_code) - int'(HP_ZERO));
    if (hp_mode) begin
      mute   = (hp_code < HP_FLOOR);
      db_sel = db_hp;
    end else begin
      mute   = (fine < SPK2_FLOOR);
      db_sel = db_spk;
    end
    if (mute) db_sel = DB_MIN;
    rom_idx = IDX_W'(db_sel - DB_MIN);
  end

endmodule

// File: rtl/gain_coef_rom.sv
module gain_coef_rom
  import sg_pkg::*;
#(
  parameter int COEF_W    = 18,
  parameter int COEF_FRAC = 14,
  parameter int IDX_W     = 7
) (
  input  logic              clk,
  input  logic              en,
  input  logic [IDX_W-1:0]  addr,
  output logic [COEF_W-1:0] q
);

  localparam int DEPTH = DB_SPAN;

  logic [COEF_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int VAL = db_to_fixed(DB_MIN + i, COEF_FRAC);
    assign table_w[i] = COEF_W'(VAL);
  end

  // registered read so the table maps onto a synchronous ROM
  always_ff @(posedge clk) begin
    if (en) begin
      if (int'(addr) < DEPTH) q <= table_w[addr];
      else                    q <= '0;
    end
  end

endmodule

// File: rtl/gain_mul_sat.sv
module gain_mul_sat #(
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 18,
  parameter int COEF_FRAC = 14
) (
  input  logic signed [SAMPLE_W-1:0] x,
  input  logic        [COEF_W-1:0]   coef,
  output logic signed [SAMPLE_W-1:0] y
);

  localparam int PW = SAMPLE_W + COEF_W + 1;
  localparam logic signed [PW-1:0] HALF  = PW'(64'sd1 <<< (COEF_FRAC - 1));
  localparam logic signed [PW-1:0] MAX_V = PW'((64'sd1 <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [PW-1:0] MIN_V = -MAX_V - PW'(1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] scaled;

  always_comb begin
    prod   = PW'(x) * $signed({1'b0, coef});
    rnd    = prod + HALF;
    scaled = rnd >>> COEF_FRAC;
    if (scaled > MAX_V)      y = MAX_V[SAMPLE_W-1:0];
    else if (scaled < MIN_V) y = MIN_V[SAMPLE_W-1:0];
    else                     y = scaled[SAMPLE_W-1:0];
  end

endmodule

// File: rtl/stereo_gain_stage.sv
module stereo_gain_stage
  import sg_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 18,
  parameter int COEF_FRAC = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hp_mode,
  input  logic [5:0]                 spk_common,
  input  logic [4:0]                 spk_fine_l,
  input  logic [4:0]                 spk_fine_r,
  input  logic [5:0]                 hp_code_l,
  input  logic [5:0]                 hp_code_r,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_l,
  input  logic signed [SAMPLE_W-1:0] in_r,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_l,
  output logic signed [SAMPLE_W-1:0] out_r
);

  localparam int NCH   = 2;
  localparam int IDX_W = $clog2(DB_SPAN);

  logic [4:0]                 fine_a  [NCH];
  logic [5:0]                 hp_a    [NCH];
  logic signed [SAMPLE_W-1:0] x_a     [NCH];
  logic [IDX_W-1:0]           idx_a   [NCH];
  logic                       mute_a  [NCH];
  logic signed [SAMPLE_W-1:0] x_s1    [NCH];
  logic                       mute_s1 [NCH];
  logic [COEF_W-1:0]          coef_s1 [NCH];
  logic signed [SAMPLE_W-1:0] y_mul   [NCH];
  logic signed [SAMPLE_W-1:0] y_q     [NCH];
  logic                       v_s1;
  logic                       v_q;

  assign fine_a[0] = spk_fine_l;
  assign fine_a[1] = spk_fine_r;
  assign hp_a[0]   = hp_code_l;
  assign hp_a[1]   = hp_code_r;
  assign x_a[0]    = in_l;
  assign x_a[1]    = in_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_s1 <= 1'b0;
      v_q  <= 1'b0;
    end else begin
      v_s1 <= in_valid;
      v_q  <= v_s1;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    gain_code_decode #(.IDX_W(IDX_W)) u_dec (
      .hp_mode (hp_mode),
      .coarse  (spk_common),
      .fine    (fine_a[ch]),
      .hp_code (hp_a[ch]),
      .rom_idx (idx_a[ch]),
      .mute    (mute_a[ch])
    );

    gain_coef_rom #(
      .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .IDX_W(IDX_W)
    ) u_rom (
      .clk  (clk),
      .en   (in_valid),
      .addr (idx_a[ch]),
      .q    (coef_s1[ch])
    );

    // stage 1: sample and mute aligned with the table read
    always_ff @(posedge clk) begin
      if (rst) begin
        x_s1[ch]    <= '0;
        mute_s1[ch] <= 1'b1;
      end else if (in_valid) begin
        x_s1[ch]    <= x_a[ch];
        mute_s1[ch] <= mute_a[ch];
      end
    end

    gain_mul_sat #(
      .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
    ) u_mul (
      .x    (x_s1[ch]),
      .coef (coef_s1[ch]),
      .y    (y_mul[ch])
    );

    // stage 2: registered result, held between valid samples
    always_ff @(posedge clk) begin
      if (rst)       y_q[ch] <= '0;
      else if (v_s1) y_q[ch] <= mute_s1[ch] ? '0 : y_mul[ch];
    end
  end

  assign out_valid = v_q;
  assign out_l     = y_q[0];
  assign out_r     = y_q[1];

endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       hp_mode,
  input logic [4:0]                 spk_fine_l,
  input logic [4:0]                 spk_fine_r,
  input logic [5:0]                 hp_code_l,
  input logic [5:0]                 hp_code_r,
  input logic                       in_valid,
  input logic signed [SAMPLE_W-1:0] in_l,
  input logic                       out_valid,
  input logic signed [SAMPLE_W-1:0] out_l,
  input logic signed [SAMPLE_W-1:0] out_r
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_l == '0 && out_r == '0)); // R1

  AST_LATENCY_FWD: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R2

  AST_LATENCY_BWD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2)); // R2

  AST_SPK_MUTE_L: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hp_mode && spk_fine_l < 5'h08) |=> ##1 (out_l == '0)); // R5

  AST_SPK_MUTE_R: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hp_mode && spk_fine_r < 5'h08) |=> ##1 (out_r == '0)); // R5

  AST_HP_MUTE_L: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hp_mode && hp_code_l < 6'h1C) |=> ##1 (out_l == '0)); // R7

  AST_HP_MUTE_R: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hp_mode && hp_code_r < 6'h1C) |=> ##1 (out_r == '0)); // R7

  AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_l == '0) |=> ##1 (out_l == '0)); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_l) && $stable(out_r))); // R10

endmodule

bind stereo_gain_stage sg_checker #(.SAMPLE_W(SAMPLE_W)) u_sg_checker (
  .clk        (clk),
  .rst        (rst),
  .hp_mode    (hp_mode),
  .spk_fine_l (spk_fine_l),
  .spk_fine_r (spk_fine_r),
  .hp_code_l  (hp_code_l),
  .hp_code_r  (hp_code_r),
  .in_valid   (in_valid),
  .in_l       (in_l),
  .out_valid  (out_valid),
  .out_l      (out_l),
  .out_r      (out_r)
);

// File: tb/test_stereo_gain_stage.sv
module test_stereo_gain_stage;

  localparam int W = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               hp_mode = 1'b0;
  logic [5:0]         spk_common = 6'h30;
  logic [4:0]         spk_fine_l = 5'h1F;
  logic [4:0]         spk_fine_r = 5'h1F;
  logic [5:0]         hp_code_l = 6'h3F;
  logic [5:0]         hp_code_r = 6'h3F;
  logic               in_valid = 1'b0;
  logic signed [W-1:0] in_l = '0;
  logic signed [W-1:0] in_r = '0;
  logic               out_valid;
  logic signed [W-1:0] out_l;
  logic signed [W-1:0] out_r;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stereo_gain_stage i_stereo_gain_stage (
    .clk(clk), .rst(rst), .hp_mode(hp_mode), .spk_common(spk_common),
    .spk_fine_l(spk_fine_l), .spk_fine_r(spk_fine_r),
    .hp_code_l(hp_code_l), .hp_code_r(hp_code_r),
    .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    total++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // loudspeaker gain from the requirement tables
  function automatic int spk_db(input int com, input int fine);
    int c;
    c = (com < 8) ? 8 : com;
    return (c - 48) + (fine - 31);
  endfunction

  function automatic int ideal(input int x, input int db);
    real y;
    int  e;
    y = real'(x) * (10.0 ** (real'(db) / 20.0));
    e = int'($floor(y + 0.5));
    if (e > 32767) e = 32767;
    if (e < -32768) e = -32768;
    return e;
  endfunction

  // drive one sample, verify two-edge latency, leave outputs ready
  task automatic push(input int xl, input int xr);
    in_l = W'(xl);
    in_r = W'(xr);
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R2 valid after one edge", int'(out_valid), 0, 0);
    @(posedge clk); #1;
    check("R2 valid after two edges", int'(out_valid), 1, 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", int'(out_valid), 0, 0);
    check("R1 out_l in reset", int'(out_l), 0, 0);
    check("R1 out_r in reset", int'(out_r), 0, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 out_valid after reset", int'(out_valid), 0, 0);

    // exact 0 dB point
    hp_mode = 1'b0; spk_common = 6'h30; spk_fine_l = 5'h1F; spk_fine_r = 5'h1F;
    push(1000, -1000);
    check("R3 0 dB left exact", int'(out_l), 1000, 0);
    check("R3 0 dB right exact", int'(out_r), -1000, 0);

    // saturation at +15 dB
    spk_common = 6'h3F;
    push(30000, -30000);
    check("R9 positive saturation", int'(out_l), 32767, 0);
    check("R9 negative saturation", int'(out_r), -32768, 0);

    // idle hold: stale inputs change while in_valid stays low
    spk_common = 6'h08; spk_fine_l = 5'h00;
    in_l = 16'sd5; in_r = 16'sd7;
    repeat (4) @(posedge clk);
    #1;
    check("R10 hold left", int'(out_l), 32767, 0);
    check("R10 hold right", int'(out_r), -32768, 0);

    // loudspeaker sweep: every coarse and fine pairing
    for (int com = 0; com < 64; com++) begin
      for (int f = 0; f < 32; f++) begin
        int fr;
        int xl;
        int xr;
        fr = (f * 7 + 3) % 32;
        xl = 16000 - com * 97 - f * 13;
        xr = -(xl / 2) - 3 - f;
        spk_common = 6'(com);
        spk_fine_l = 5'(f);
        spk_fine_r = 5'(fr);
        hp_code_l  = 6'h00;
        hp_code_r  = 6'h00;
        push(xl, xr);
        if (f < 8) check("R5 left mute", int'(out_l), 0, 0);
        else check("R3/R4/R6/R8 left gain", int'(out_l), ideal(xl, spk_db(com, f)), 1);
        if (fr < 8) check("R5 right mute", int'(out_r), 0, 0);
        else check("R4/R6/R8 right gain", int'(out_r), ideal(xr, spk_db(com, fr)), 1);
      end
    end

    // headphone sweep with loudspeaker codes set to mute values
    hp_mode = 1'b1;
    spk_common = 6'h00; spk_fine_l = 5'h00; spk_fine_r = 5'h03;
    for (int c = 0; c < 64; c++) begin
      int cr;
      int xl;
      int xr;
      cr = 63 - c;
      xl = 15000 - c * 111;
      xr = -14000 + c * 57;
      hp_code_l = 6'(c);
      hp_code_r = 6'(cr);
      push(xl, xr);
      if (c < 28) check("R7 left mute", int'(out_l), 0, 0);
      else check("R7 left gain", int'(out_l), ideal(xl, 2 * (c - 63)), 1);
      if (cr < 28) check("R7 right mute", int'(out_r), 0, 0);
      else check("R7 right gain", int'(out_r), ideal(xr, 2 * (cr - 63)), 1);
    end

    // zero input at the highest gain
    hp_mode = 1'b0; spk_common = 6'h3F; spk_fine_l = 5'h1F; spk_fine_r = 5'h1F;
    push(0, 0);
    check("R8 zero in left", int'(out_l), 0, 0);
    check("R8 zero in right", int'(out_r), 0, 0);

    @(posedge clk); #1;
    check("R2 valid single cycle", int'(out_valid), 0, 0);

    done = 1'b1;
    finish_run();
  end

endmodule